// File: doc/BRIEF.md
# Protected Module Reset-State Controller

The controller keeps a two-bit operating state for each of a parameterised number of peripheral modules. It drives one active-low reset and one clock enable per module from that state. Software sets a wanted state in a bank of request words and reads the state actually reached from a second bank with the same layout. Each module moves one legal step at a time. A move takes effect a fixed number of clock cycles after the request changes. A word has settled once its status reads equal to its request.

Request writes are guarded by a key register. Only one magic value opens the guard, and any other value written there closes it again. A request that asks for a move the state machine does not allow is dropped, and the word it belongs to raises a sticky error flag. The register port is a plain single-cycle bus with no back-pressure. A write completes on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `mrs_ctrl`

## Requirements
- R1: State codes are 0 standby, 1 reset, 2 stop, 3 run. Module n sits in bits [2*(n%16)+1:2*(n%16)] of word n/16. Request word w is at 0x900+4*w and status word w is at 0x960+4*w.
- R2: After reset, every request and status field reads 3 (run), the guard reads 0 (locked) and the error register reads 0.
- R3: Writing 0xA5A5A501 to 0xCF4 opens the guard. Writing any other value there closes it. A read of 0xCF4 returns 1 when open and 0 when locked.
- R4: While the guard is locked, writes to request words are ignored, and the request and status read back unchanged.
- R5: After an accepted request change, the status field stays at its old value for three rising edges and takes the new value on the fourth rising edge after the write edge.
- R6: The only legal moves are stop to standby, stop to run, standby to reset, run to reset, run to stop and reset to run. A request equal to the current status is also accepted.
- R7: A request that is not a legal move from the current status is dropped. The request field keeps its old value, the status does not change, and bit w of the error register at 0xCF8 is set and stays set. Writing 1 to bit w clears it.
- R8: `mod_rst_n[n]` is low exactly while module n reports reset. `mod_clk_en[n]` is high exactly while module n reports run.
- R9: A new accepted request during a pending move restarts the latency. The status then takes the newest request value four edges after that write.
- R10: A read of an address that maps to no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| mod_rst_n | output | NUM_MOD | Active-low reset per module |
| mod_clk_en | output | NUM_MOD | Clock enable per module |

## Verification
All sixteen current-state and requested-state pairs are tried. Each pair uses a different module spread over both words, so legal steps, accepted no-op requests and rejected moves are told apart by their status timing and by the error flags. Locked writes, wrong-key writes and the key value that closes the guard separate the effect of the guard from the effect of the request logic. A retarget during a pending move shows that the latency restarts rather than completing toward the older request.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam logic [1:0] ST_STBY = 2'd0;
  localparam logic [1:0] ST_RST  = 2'd1;
  localparam logic [1:0] ST_STOP = 2'd2;
  localparam logic [1:0] ST_RUN  = 2'd3;

  // legal one-step moves between reported states
  function automatic logic step_ok(input logic [1:0] from_s, input logic [1:0] to_s);
    logic ok;
    ok = (from_s == to_s);
    unique case (from_s)
      ST_STOP: ok = ok || (to_s == ST_STBY) || (to_s == ST_RUN);
      ST_STBY: ok = ok || (to_s == ST_RST);
      ST_RUN:  ok = ok || (to_s == ST_RST) || (to_s == ST_STOP);
      default: ok = ok || (to_s == ST_RUN);
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/mrs_lock.sv
module mrs_lock #(
  parameter logic [31:0] KEY_OPEN = 32'hA5A5A501
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_data,
  output logic        open_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      open_o <= 1'b0;
    else if (key_we) open_o <= (key_data == KEY_OPEN);
  end

  p_wrong_key_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key_data != KEY_OPEN) |=> !open_o);
  p_key_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key_data == KEY_OPEN) |=> open_o);
endmodule

// File: rtl/mrs_slot.sv
module mrs_slot
  import mrs_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_val,
  output logic [1:0] req_o,
  output logic [1:0] stat_o,
  output logic       reject_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;
  logic          change;

  assign change   = wr_en && (wr_val != req_o);
  assign reject_o = change && !step_ok(stat_o, wr_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o  <= ST_RUN;
      stat_o <= ST_RUN;
      cnt_q  <= '0;
    end else if (change && !reject_o) begin
      req_o <= wr_val;
      cnt_q <= '0;
    end else if (req_o != stat_o) begin
      if (cnt_q == CW'(LAT - 1)) begin
        stat_o <= req_o;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  p_step_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o != $past(stat_o)) |-> step_ok($past(stat_o), stat_o));
  p_stat_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o != $past(stat_o)) |-> (stat_o == $past(req_o)));
  p_latency_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o != $past(stat_o)) |-> ($past(cnt_q) == CW'(LAT - 1)));
  p_reject_keeps_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |=> $stable(req_o));
endmodule

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
  import mrs_pkg::*;
#(
  parameter int          NUM_MOD   = 32,
  parameter int          AW        = 12,
  parameter int          LAT       = 4,
  parameter logic [11:0] REQ_BASE  = 12'h900,
  parameter logic [11:0] STAT_BASE = 12'h960,
  parameter logic [11:0] PROT_ADDR = 12'hCF4,
  parameter logic [11:0] ERR_ADDR  = 12'hCF8,
  parameter logic [31:0] KEY_OPEN  = 32'hA5A5A501
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_MOD-1:0] mod_rst_n,
  output logic [NUM_MOD-1:0] mod_clk_en
);
  localparam int FPW = 16;
  localparam int NW  = (NUM_MOD + FPW - 1) / FPW;
  localparam int NF  = NW * FPW;
  localparam int WIW = (NW > 1) ? $clog2(NW) : 1;

  logic [AW-1:0]  req_off, stat_off;
  logic           req_hit, stat_hit, open, wr_req;
  logic [WIW-1:0] req_widx, stat_widx;
  logic [2*NF-1:0] req_flat, stat_flat;
  logic [NF-1:0]  rej;
  logic [NW-1:0]  err_q, err_set, err_clr;

  assign req_off   = bus_addr - AW'(REQ_BASE);
  assign stat_off  = bus_addr - AW'(STAT_BASE);
  assign req_hit   = (req_off < AW'(4 * NW)) && (req_off[1:0] == 2'b00);
  assign stat_hit  = (stat_off < AW'(4 * NW)) && (stat_off[1:0] == 2'b00);
  assign req_widx  = req_off[2 +: WIW];
  assign stat_widx = stat_off[2 +: WIW];
  assign wr_req    = bus_we && open && req_hit;

  mrs_lock #(.KEY_OPEN(KEY_OPEN)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (bus_we && (bus_addr == AW'(PROT_ADDR))),
    .key_data (bus_wdata),
    .open_o   (open)
  );

  for (genvar n = 0; n < NF; n++) begin : g_mod
    if (n < NUM_MOD) begin : g_slot
      mrs_slot #(.LAT(LAT)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_req && (req_widx == WIW'(n / FPW))),
        .wr_val   (bus_wdata[2*(n%FPW) +: 2]),
        .req_o    (req_flat[2*n +: 2]),
        .stat_o   (stat_flat[2*n +: 2]),
        .reject_o (rej[n])
      );
      assign mod_rst_n[n]  = (stat_flat[2*n +: 2] != ST_RST);
      assign mod_clk_en[n] = (stat_flat[2*n +: 2] == ST_RUN);
    end else begin : g_pad
      assign req_flat[2*n +: 2]  = 2'b00;
      assign stat_flat[2*n +: 2] = 2'b00;
      assign rej[n]              = 1'b0;
    end
  end

  always_comb begin
    for (int w = 0; w < NW; w++) err_set[w] = |rej[FPW*w +: FPW];
    err_clr = (bus_we && bus_addr == AW'(ERR_ADDR)) ? bus_wdata[NW-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (err_q & ~err_clr) | err_set;
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (req_hit && req_widx == WIW'(w))   bus_rdata = req_flat[32*w +: 32];
      if (stat_hit && stat_widx == WIW'(w)) bus_rdata = stat_flat[32*w +: 32];
    end
    if (bus_addr == AW'(PROT_ADDR)) bus_rdata = {31'b0, open};
    if (bus_addr == AW'(ERR_ADDR))  bus_rdata = 32'(err_q);
  end

  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && bus_we && req_hit) |=> $stable(req_flat));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(ERR_ADDR)) |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: tb/mrs_ctrl_bench.sv
module mrs_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 32;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NM-1:0] mod_rst_n, mod_clk_en;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] mreq [NM];
  logic [1:0] mstat [NM];

  always #(CLK_PERIOD/2) clk = ~clk;

  mrs_ctrl u_mrs_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mod_rst_n(mod_rst_n), .mod_clk_en(mod_clk_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic bit legal(input logic [1:0] f, input logic [1:0] t);
    if (f == t) return 1;
    if (f == 2 && (t == 0 || t == 3)) return 1;
    if (f == 0 && t == 1) return 1;
    if (f == 3 && (t == 1 || t == 2)) return 1;
    if (f == 1 && t == 3) return 1;
    return 0;
  endfunction

  function automatic logic [1:0] hop(input logic [1:0] c, input logic [1:0] t);
    if (legal(c, t)) return t;
    case (c)
      2'd0:    return 2'd1;
      2'd1:    return 2'd3;
      2'd2:    return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [31:0] reqword(input int w, input int m, input logic [1:0] v);
    logic [31:0] d;
    for (int f = 0; f < 16; f++) d[2*f +: 2] = mreq[w*16+f];
    d[2*(m%16) +: 2] = v;
    return d;
  endfunction

  task automatic stat_field(input int m, output logic [1:0] v);
    logic [31:0] d;
    rd(12'h960 + 12'(4*(m/16)), d);
    v = d[2*(m%16) +: 2];
  endtask

  task automatic step(input int m, input logic [1:0] to);
    logic [31:0] d;
    logic [1:0] v, from;
    int w;
    w = m / 16;
    from = mstat[m];
    wr(12'h900 + 12'(4*w), reqword(w, m, to));
    rd(12'h900 + 12'(4*w), d);
    if (legal(from, to)) begin
      chk(d[2*(m%16) +: 2] == to, "R6 legal request accepted", 32'(d[2*(m%16) +: 2]), 32'(to));
      tick(3);
      stat_field(m, v);
      chk(v == from, "R5 status held three edges", 32'(v), 32'(from));
      tick(1);
      stat_field(m, v);
      chk(v == to, "R5 status on fourth edge", 32'(v), 32'(to));
      chk(mod_rst_n[m] == (to != 2'd1), "R8 mod_rst_n", 32'(mod_rst_n[m]), 32'(to != 2'd1));
      chk(mod_clk_en[m] == (to == 2'd3), "R8 mod_clk_en", 32'(mod_clk_en[m]), 32'(to == 2'd3));
      mreq[m] = to;
      mstat[m] = to;
    end else begin
      chk(d[2*(m%16) +: 2] == from, "R7 illegal request dropped", 32'(d[2*(m%16) +: 2]), 32'(from));
      rd(12'hCF8, d);
      chk(d == (32'd1 << w), "R7 error bit set", d, 32'd1 << w);
      tick(5);
      stat_field(m, v);
      chk(v == from, "R7 status unchanged", 32'(v), 32'(from));
      rd(12'hCF8, d);
      chk(d == (32'd1 << w), "R7 error bit sticky", d, 32'd1 << w);
      wr(12'hCF8, 32'd1 << w);
      rd(12'hCF8, d);
      chk(d == 32'd0, "R7 error bit cleared", d, 32'd0);
    end
  endtask

  task automatic go(input int m, input logic [1:0] t);
    while (mstat[m] != t) step(m, hop(mstat[m], t));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0] v;
    for (int i = 0; i < NM; i++) begin mreq[i] = 2'd3; mstat[i] = 2'd3; end
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 R2: reset state in both banks
    for (int w = 0; w < 2; w++) begin
      rd(12'h900 + 12'(4*w), d);
      chk(d == 32'hFFFF_FFFF, "R2 request reset value", d, 32'hFFFF_FFFF);
      rd(12'h960 + 12'(4*w), d);
      chk(d == 32'hFFFF_FFFF, "R1 status reset value", d, 32'hFFFF_FFFF);
    end
    rd(12'hCF4, d);
    chk(d == 32'd0, "R2 guard locked", d, 32'd0);
    rd(12'hCF8, d);
    chk(d == 32'd0, "R2 error clear", d, 32'd0);
    chk(mod_rst_n == '1 && mod_clk_en == '1, "R8 outputs after reset", {mod_rst_n[15:0], mod_clk_en[15:0]}, 32'hFFFF_FFFF);

    // R10: unmapped reads
    rd(12'h100, d);
    chk(d == 32'd0, "R10 unmapped read", d, 32'd0);
    rd(12'h968, d);
    chk(d == 32'd0, "R10 beyond status bank", d, 32'd0);

    // R4: locked write ignored
    wr(12'h900, 32'hAAAA_AAAA);
    tick(6);
    rd(12'h900, d);
    chk(d == 32'hFFFF_FFFF, "R4 locked request unchanged", d, 32'hFFFF_FFFF);
    rd(12'h960, d);
    chk(d == 32'hFFFF_FFFF, "R4 locked status unchanged", d, 32'hFFFF_FFFF);

    // R3: open the guard
    wr(12'hCF4, 32'hA5A5A501);
    rd(12'hCF4, d);
    chk(d == 32'd1, "R3 guard opened", d, 32'd1);

    // R5 R6 R7 R8: every from/to pair on its own module
    for (int p = 0; p < 16; p++) begin
      int m;
      m = p * 2 + (p % 2);
      go(m, 2'(p / 4));
      step(m, 2'(p % 4));
    end

    // R9: retarget during a pending move
    go(5, 2'd3);
    wr(12'h900, reqword(0, 5, 2'd2));
    mreq[5] = 2'd2;
    tick(1);
    wr(12'h900, reqword(0, 5, 2'd1));
    mreq[5] = 2'd1;
    tick(3);
    stat_field(5, v);
    chk(v == 2'd3, "R9 latency restarted", 32'(v), 32'd3);
    tick(1);
    stat_field(5, v);
    chk(v == 2'd1, "R9 newest request reached", 32'(v), 32'd1);
    mstat[5] = 2'd1;

    // R3 R4: wrong key and locking key close the guard
    wr(12'hCF4, 32'h1234_5678);
    rd(12'hCF4, d);
    chk(d == 32'd0, "R3 wrong key locks", d, 32'd0);
    wr(12'hCF4, 32'hA5A5A501);
    wr(12'hCF4, 32'hA5A5A500);
    rd(12'hCF4, d);
    chk(d == 32'd0, "R3 locking key", d, 32'd0);
    wr(12'h900, reqword(0, 5, 2'd3));
    tick(6);
    stat_field(5, v);
    chk(v == 2'd1, "R4 locked retry ignored", 32'(v), 32'd1);
    chk(mod_rst_n[5] == 1'b0, "R8 held in reset", 32'(mod_rst_n[5]), 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule